// File: doc/BRIEF.md
# Decision Feedback Equalizer with FIR and Recursive Tail Cancellation

This block is a digital decision feedback equalizer for links whose post-cursor interference fades out exponentially, as on smooth on-chip or carrier wires. Each accepted sample has two feedback terms taken away from it. One is a single FIR tap, weighted by the previous decision, which removes the large first post-cursor. The other is a first-order low-pass recursive term that models the whole remaining tail. The block then slices the result to a binary decision.

The recursive branch takes its input from the decision two symbols back. Its cancellation therefore starts at the second post-cursor and does not overlap the FIR tap. The tail height and its decay rate are set by separate inputs. With the decay set to zero the block acts as a plain two-tap DFE. Samples enter as a valid-qualified stream. Each accepted sample gives one decision, together with the equalized soft value, one cycle later.

Top module: `dfe_fir_iir`

## Requirements
- R1: After reset, dec_valid_o, dec_o and eq_o are 0. Both past decisions and the recursive state are cleared, so both count as 0 in feedback. The first sample after reset comes out with eq_o equal to the sample.
- R2: A decision of +1 appears as dec_o = 1 and a decision of −1 as dec_o = 0. The decision is +1 when the equalized value is zero or positive.
- R3: Each cycle with sample_valid_i high gives exactly one cycle of dec_valid_o, on the next cycle. dec_valid_o is low in every other cycle.
- R4: The equalized value is eq = sample − w1·d(k−1) − tail(k), where d is ±1, or 0 before any decision exists.
- R5: The recursive branch is fed by d(k−2). A change in amplitude has no effect on the first two samples after reset, and with decay 0 the third sample is reduced by exactly amp·d(0).
- R6: The state is kept with FRAC_W extra fractional bits and updated as s(k) = floor(s(k−1)·decay / 2^DECAY_W) + amp·d(k−2)·2^FRAC_W. tail(k) is floor(s(k) / 2^FRAC_W). decay is unsigned and amp is signed.
- R7: The updated state saturates to the signed range of SAMPLE_W+2+FRAC_W bits. With the default widths, tail is limited to −2048 … +2047.
- R8: With decay = 0, eq(k) = sample − w1·d(k−1) − amp·d(k−2), which is a two-tap FIR DFE.
- R9: Cycles with sample_valid_i low change neither the decision history nor the recursive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample qualifier |
| sample_i | input | SAMPLE_W | Signed received sample |
| w1_i | input | COEF_W | Signed first post-cursor tap |
| tail_amp_i | input | COEF_W | Signed recursive tail amplitude |
| tail_decay_i | input | DECAY_W | Unsigned decay factor, value/2^DECAY_W |
| dec_valid_o | output | 1 | Decision qualifier |
| dec_o | output | 1 | Decision, 1 = +1, 0 = −1 |
| eq_o | output | SAMPLE_W+3 | Signed equalized value for the decision |

## Verification
Some properties are checked on every cycle. Output valid must follow input valid by exactly one cycle. The stored previous decision must agree with the decision just sent out. The older history slot must take over the newer one on each accepted sample. The recursive state must not move while no sample is accepted. The arithmetic needs a reference model, so only the bench scenarios can show it: the subtraction of the FIR tap, the two-symbol lag of the recursion, floor rounding of the fractional state, saturation under a long same-sign run, and the collapse to a two-tap FIR when decay is zero.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  // decision symbol: +1, -1, or 0 when no decision exists yet
  typedef logic signed [1:0] sym_t;
  localparam sym_t SYM_POS  = 2'sb01;
  localparam sym_t SYM_NEG  = 2'sb11;
  localparam sym_t SYM_NONE = 2'sb00;
endpackage

// File: rtl/dfe_history.sv
module dfe_history
  import dfe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic dec_i,
  output sym_t d1_o,
  output sym_t d2_o
);
  sym_t d1_q, d2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q <= SYM_NONE;
      d2_q <= SYM_NONE;
    end else if (adv_i) begin
      d1_q <= dec_i ? SYM_POS : SYM_NEG;
      d2_q <= d1_q;
    end
  end

  assign d1_o = d1_q;
  assign d2_o = d2_q;

  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> d2_q == $past(d1_q)); // R5
endmodule

// File: rtl/dfe_iir_tail.sv
module dfe_iir_tail
  import dfe_pkg::*;
#(
  parameter int COEF_W  = 8,
  parameter int DECAY_W = 8,
  parameter int FRAC_W  = 8,
  parameter int INT_W   = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  input  logic signed [COEF_W-1:0] amp_i,
  input  logic        [DECAY_W-1:0] decay_i,
  input  sym_t                     d2_i,
  output logic signed [INT_W-1:0]  tail_o
);
  localparam int STATE_W = INT_W + FRAC_W;
  localparam int PROD_W  = STATE_W + DECAY_W + 1;
  localparam logic signed [PROD_W-1:0] S_MAX = PROD_W'((64'sd1 <<< (STATE_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] S_MIN = -S_MAX - 1;

  logic signed [STATE_W-1:0] s_q, s_next;
  logic signed [PROD_W-1:0]  prod, decayed, amp_fx, inj, sum;

  always_comb begin
    prod    = PROD_W'(s_q) * PROD_W'($signed({1'b0, decay_i}));
    decayed = prod >>> DECAY_W;
    amp_fx  = PROD_W'(amp_i) <<< FRAC_W;
    case (d2_i)
      SYM_POS: inj = amp_fx;
      SYM_NEG: inj = -amp_fx;
      default: inj = '0;
    endcase
    sum = decayed + inj;
    if (sum > S_MAX)      s_next = STATE_W'(S_MAX);
    else if (sum < S_MIN) s_next = STATE_W'(S_MIN);
    else                  s_next = STATE_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s_q <= '0;
    else if (adv_i) s_q <= s_next;
  end

  // floor of the freshly updated state feeds the current sample
  assign tail_o = INT_W'(s_next >>> FRAC_W);

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(s_q)); // R9
endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer
  import dfe_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = 8,
  parameter int INT_W    = 12,
  parameter int EQ_W     = 13
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [COEF_W-1:0]   w1_i,
  input  sym_t                       d1_i,
  input  logic signed [INT_W-1:0]    tail_i,
  output logic                       dec_now_o,
  output logic                       valid_o,
  output logic                       dec_o,
  output logic signed [EQ_W-1:0]     eq_o
);
  logic signed [EQ_W-1:0] y_x, fir_x, tail_x, z;

  always_comb begin
    y_x    = EQ_W'(sample_i);
    tail_x = EQ_W'(tail_i);
    case (d1_i)
      SYM_POS: fir_x = EQ_W'(w1_i);
      SYM_NEG: fir_x = -EQ_W'(w1_i);
      default: fir_x = '0;
    endcase
    z = y_x - fir_x - tail_x;
  end

  assign dec_now_o = ~z[EQ_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dec_o   <= 1'b0;
      eq_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dec_o <= dec_now_o;
        eq_o  <= z;
      end
    end
  end
endmodule

// File: rtl/dfe_fir_iir.sv
module dfe_fir_iir
  import dfe_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = 8,
  parameter int DECAY_W  = 8,
  parameter int FRAC_W   = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sample_valid_i,
  input  logic signed [SAMPLE_W-1:0]  sample_i,
  input  logic signed [COEF_W-1:0]    w1_i,
  input  logic signed [COEF_W-1:0]    tail_amp_i,
  input  logic        [DECAY_W-1:0]   tail_decay_i,
  output logic                        dec_valid_o,
  output logic                        dec_o,
  output logic signed [SAMPLE_W+2:0]  eq_o
);
  localparam int INT_W = SAMPLE_W + 2;
  localparam int EQ_W  = SAMPLE_W + 3;

  sym_t d1, d2;
  logic dec_now;
  logic signed [INT_W-1:0] tail;

  dfe_history u_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (sample_valid_i),
    .dec_i (dec_now),
    .d1_o  (d1),
    .d2_o  (d2)
  );

  dfe_iir_tail #(
    .COEF_W (COEF_W),
    .DECAY_W(DECAY_W),
    .FRAC_W (FRAC_W),
    .INT_W  (INT_W)
  ) u_tail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (sample_valid_i),
    .amp_i  (tail_amp_i),
    .decay_i(tail_decay_i),
    .d2_i   (d2),
    .tail_o (tail)
  );

  dfe_slicer #(
    .SAMPLE_W(SAMPLE_W),
    .COEF_W  (COEF_W),
    .INT_W   (INT_W),
    .EQ_W    (EQ_W)
  ) u_slice (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (sample_valid_i),
    .sample_i (sample_i),
    .w1_i     (w1_i),
    .d1_i     (d1),
    .tail_i   (tail),
    .dec_now_o(dec_now),
    .valid_o  (dec_valid_o),
    .dec_o    (dec_o),
    .eq_o     (eq_o)
  );

  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> dec_valid_o); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !dec_valid_o); // R3
  AST_DEC_IN_HISTORY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (d1 == (dec_o ? SYM_POS : SYM_NEG))); // R2
endmodule

// File: tb/tb_dfe_fir_iir.sv
module tb_dfe_fir_iir;
  localparam int SAMPLE_W = 10;
  localparam int COEF_W   = 8;
  localparam int DECAY_W  = 8;
  localparam int FRAC_W   = 8;
  localparam longint S_MAX = (64'sd1 <<< (SAMPLE_W + 2 + FRAC_W - 1)) - 1;
  localparam longint S_MIN = -S_MAX - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_valid_i = 1'b0;
  logic signed [SAMPLE_W-1:0] sample_i = '0;
  logic signed [COEF_W-1:0] w1_i = '0, tail_amp_i = '0;
  logic [DECAY_W-1:0] tail_decay_i = '0;
  logic dec_valid_o, dec_o;
  logic signed [SAMPLE_W+2:0] eq_o;

  always #4 clk = ~clk;

  dfe_fir_iir dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(sample_valid_i),
    .sample_i(sample_i), .w1_i(w1_i), .tail_amp_i(tail_amp_i),
    .tail_decay_i(tail_decay_i), .dec_valid_o(dec_valid_o),
    .dec_o(dec_o), .eq_o(eq_o)
  );

  typedef struct {
    logic   dec;
    longint eq;
    string  tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  string cur_tag = "R1";
  int m_d1, m_d2;
  longint m_s, last_eq;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    sample_valid_i = 1'b0;
    rst_ni = 1'b0;
    m_d1 = 0; m_d2 = 0; m_s = 0;
    repeat (2) @(negedge clk);
    check(dec_valid_o == 1'b0, "R1 valid", longint'(dec_valid_o), 0);
    check(dec_o == 1'b0 && eq_o == '0, "R1 outputs", longint'(eq_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic send(input int y);
    longint decayed, sum, tail, z;
    exp_t e;
    @(negedge clk);
    sample_valid_i = 1'b1;
    sample_i = SAMPLE_W'(y);
    decayed = (m_s * longint'(tail_decay_i)) >>> DECAY_W;
    sum = decayed + longint'(tail_amp_i) * m_d2 * (64'sd1 <<< FRAC_W);
    if (sum > S_MAX) sum = S_MAX;
    if (sum < S_MIN) sum = S_MIN;
    m_s = sum;
    tail = sum >>> FRAC_W;
    z = longint'(y) - longint'(w1_i) * m_d1 - tail;
    e.dec = (z >= 0);
    e.eq = z;
    e.tag = cur_tag;
    exp_q.push_back(e);
    m_d2 = m_d1;
    m_d1 = e.dec ? 1 : -1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk) sample_valid_i = 1'b0;
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && dec_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected output", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          last_eq = longint'(eq_o);
          check(longint'(eq_o) == e.eq, {e.tag, " eq"}, longint'(eq_o), e.eq);
          check(dec_o == e.dec, {e.tag, " R2 dec"}, longint'(dec_o), longint'(e.dec));
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: first sample ignores all feedback
    w1_i = 8'sd100; tail_amp_i = 8'sd50; tail_decay_i = 8'd200;
    do_reset();
    cur_tag = "R1";
    send(-3);
    idle(3);
    check(last_eq == -3, "R1 first eq", last_eq, -3);

    // R2: exactly zero equalized value decides +1
    w1_i = 8'sd0; tail_amp_i = 8'sd0; tail_decay_i = 8'd0;
    do_reset();
    cur_tag = "R2";
    send(0); send(-1); send(0);
    idle(3);

    // R4: FIR tap only
    w1_i = 8'sd37;
    do_reset();
    cur_tag = "R4";
    send(50); send(-20); send(30); send(-60); send(10); send(-5);
    idle(3);

    // R5: two-symbol lag of the recursive branch
    w1_i = 8'sd0; tail_amp_i = 8'sd60; tail_decay_i = 8'd0;
    do_reset();
    cur_tag = "R5";
    send(100); send(-100); send(5);
    idle(3);
    check(last_eq == -55, "R5 third eq", last_eq, -55);
    send(5);
    idle(3);
    check(last_eq == 65, "R5 fourth eq", last_eq, 65);

    // R8: decay zero gives two-tap FIR
    w1_i = -8'sd45; tail_amp_i = 8'sd33; tail_decay_i = 8'd0;
    do_reset();
    cur_tag = "R8";
    for (int i = 0; i < 40; i++) send($urandom_range(0, 1000) - 500);
    idle(3);

    // R6: recursion with several decay values and signs
    for (int j = 0; j < 4; j++) begin
      w1_i = COEF_W'($urandom_range(0, 255));
      tail_amp_i = COEF_W'($urandom_range(0, 255));
      tail_decay_i = DECAY_W'(60 * j + 20);
      do_reset();
      cur_tag = "R6";
      for (int i = 0; i < 60; i++) send($urandom_range(0, 1000) - 500);
      idle(3);
    end

    // R9: idle gaps leave history and state untouched
    w1_i = 8'sd25; tail_amp_i = -8'sd70; tail_decay_i = 8'd230;
    do_reset();
    cur_tag = "R9";
    for (int i = 0; i < 30; i++) begin
      send($urandom_range(0, 600) - 300);
      idle($urandom_range(0, 3));
    end
    idle(3);

    // R7: long same-sign run drives the state into saturation
    w1_i = 8'sd0; tail_amp_i = -8'sd127; tail_decay_i = 8'd255;
    do_reset();
    cur_tag = "R7";
    for (int i = 0; i < 120; i++) send(500);
    idle(3);
    check(last_eq == 500 + 2048, "R7 saturated eq", last_eq, 2548);

    check(exp_q.size() == 0, "R3 pending results", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule